// File: doc/BRIEF.md
# Interval, Fixed-Period and Watchdog Timer Unit

This block gathers three timers of an embedded core behind one 32-bit control word and one 32-bit status word. A down-counting interval timer is loaded from a reload port and decremented once per time-base tick. A fixed-period timer and a watchdog each watch one bit of an external time-base value, picked from four parameterised taps by a control field. Every 0-to-1 transition of the picked bit counts as one period.

Each timer records its events in the status word, and software clears status bits by writing ones to them. The watchdog goes through two warning stages before it acts. On the third period it copies the reset kind chosen in the control word into the status word and sends a one-cycle request on the matching reset output. The time base is not part of the block: its value and its tick strobe come in on input ports.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the control word, the status word, all three interrupt outputs and all three reset request outputs are zero.
- R2: Suppose control bit 26 is 1 and a reload value N of 2 or more is written. Status bit 27 then sets on the Nth tick after the write. irq_pit equals status bit 27 AND control bit 26.
- R3: With control bit 22 set, the interval timer reloads N after each expiry and expires again every N ticks. With bit 22 clear, it stops after one expiry.
- R4: A reload value of 0 or 1 never expires. With control bit 26 clear, the timer never expires. Clearing bit 26 stops a running countdown, and only a new reload write restarts it.
- R5: Control bits 25:24 select fixed-period tap FIT_TAP0..FIT_TAP3. Each rise of that time-base bit sets status bit 26, and rises of other bits do not. irq_fit equals status bit 26 AND control bit 23.
- R6: Control bits 31:30 select watchdog tap WDT_TAP0..WDT_TAP3. Only a rise of the selected bit advances the watchdog.
- R7: On a watchdog period with status bit 31 clear, bit 31 sets. With bit 31 set and bit 30 clear, bit 30 sets. irq_wdt equals status bit 30 AND control bit 27.
- R8: On a watchdog period with status bits 31 and 30 both set, control bits 29:28 are copied into status bits 29:28. The matching reset output then pulses for exactly one cycle: code 0 pulses none, 1 rst_core, 2 rst_chip, 3 rst_sys.
- R9: A status write clears each status bit whose write bit is 1 and leaves the others unchanged. If an event sets a bit in the same cycle as a write clears it, the bit ends up set.
- R10: A control write is stored whole and appears on ctl_q one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_value | input | TB_W | Time-base value whose tap bits clock the fixed-period and watchdog timers |
| tb_tick | input | 1 | Interval timer decrement strobe |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| sts_we | input | 1 | Status write-ones-to-clear strobe |
| sts_wdata | input | 32 | Status clear mask |
| rld_we | input | 1 | Reload value write strobe |
| rld_wdata | input | RLD_W | Reload value |
| ctl_q | output | 32 | Current control word |
| sts_q | output | 32 | Current status word |
| irq_pit | output | 1 | Interval timer interrupt |
| irq_fit | output | 1 | Fixed-period interrupt |
| irq_wdt | output | 1 | Watchdog interrupt |
| rst_core | output | 1 | Core reset request pulse |
| rst_chip | output | 1 | Chip reset request pulse |
| rst_sys | output | 1 | System reset request pulse |

## Verification
The tap selectors are swept over every select code against a single rise on every time-base bit, one bit at a time. This separates the selected tap from its neighbours for both the fixed-period timer and the first watchdog stage. The interval timer is run with reload values 2 through 6, both with and without auto-reload, and status is checked tick by tick, so an off-by-one count or a missing reload shows up. The watchdog is stepped through all four reset codes to tell the three pulse outputs apart, and the clear-versus-set collision is driven on purpose.

// File: rtl/tmr_unit_pkg.sv
package tmr_unit_pkg;

   // control word field positions
   localparam int unsigned C_WPER_HI = 31;
   localparam int unsigned C_WPER_LO = 30;
   localparam int unsigned C_WRST_HI = 29;
   localparam int unsigned C_WRST_LO = 28;
   localparam int unsigned C_WIE     = 27;
   localparam int unsigned C_PIE     = 26;
   localparam int unsigned C_FPER_HI = 25;
   localparam int unsigned C_FPER_LO = 24;
   localparam int unsigned C_FIE     = 23;
   localparam int unsigned C_ARLD    = 22;

   // status word bit positions
   localparam int unsigned S_WSTG1   = 31;
   localparam int unsigned S_WSTG2   = 30;
   localparam int unsigned S_WRS_HI  = 29;
   localparam int unsigned S_WRS_LO  = 28;
   localparam int unsigned S_PIT     = 27;
   localparam int unsigned S_FIT     = 26;
   localparam int unsigned S_LOW     = 26;

   localparam int unsigned N_TAPS    = 4;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_CORE = 2'd1,
      RK_CHIP = 2'd2,
      RK_SYS  = 2'd3
   } rst_kind_e;

endpackage

// File: rtl/tap_rise_sel.sv
module tap_rise_sel #(
   parameter int unsigned TB_W = 12,
   parameter int unsigned TAP0 = 2,
   parameter int unsigned TAP1 = 3,
   parameter int unsigned TAP2 = 4,
   parameter int unsigned TAP3 = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TB_W-1:0] tb_value,
   input  logic [1:0]      sel,
   output logic            rise
);
   import tmr_unit_pkg::*;

   logic [N_TAPS-1:0] hit;
   logic              unused_tb;

   assign unused_tb = ^tb_value;

   for (genvar gi = 0; gi < N_TAPS; gi++) begin : g_tap
      localparam int unsigned T = (gi == 0) ? TAP0 :
                                  (gi == 1) ? TAP1 :
                                  (gi == 2) ? TAP2 : TAP3;
      if (T >= TB_W) begin : g_bad_tap
         $error("tap_rise_sel: tap index beyond time-base width");
      end
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= tb_value[T];
      end
      assign hit[gi] = tb_value[T] & ~prev_q;
   end

   assign rise = hit[sel];

endmodule

// File: rtl/interval_counter.sv
module interval_counter #(
   parameter int unsigned RLD_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             auto_rld,
   input  logic             tick,
   input  logic             ld_we,
   input  logic [RLD_W-1:0] ld_val,
   output logic             expire
);
   localparam logic [RLD_W-1:0] ONE = RLD_W'(1);

   if (RLD_W < 2) begin : g_bad_width
      $error("interval_counter: reload width must be at least 2");
   end

   logic [RLD_W-1:0] reload_q;
   logic [RLD_W-1:0] cnt_q;
   logic             running_q;
   logic             last_tick;

   assign last_tick = running_q && en && tick && !ld_we && (cnt_q == ONE);
   assign expire    = last_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q  <= '0;
         cnt_q     <= '0;
         running_q <= 1'b0;
      end else if (ld_we) begin
         reload_q  <= ld_val;
         cnt_q     <= ld_val;
         running_q <= en && (ld_val > ONE);
      end else if (!en) begin
         running_q <= 1'b0;
      end else if (running_q && tick) begin
         if (cnt_q == ONE) begin
            if (auto_rld) cnt_q <= reload_q;
            else          running_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   // R4: a running counter always holds a usable reload value
   a_r4_run_needs_reload: assert property (@(posedge clk) disable iff (!rst_n)
      running_q |-> (reload_q > ONE));

   // R4: dropping the enable halts the countdown
   a_r4_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && !en) |=> !running_q);

   // R3: without auto-reload an expiry leaves the counter idle
   a_r3_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
      (last_tick && !auto_rld) |=> !running_q);

endmodule

// File: rtl/watchdog_seq.sv
module watchdog_seq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       period_hit,
   input  logic       stg1,
   input  logic       stg2,
   input  logic [1:0] rst_code,
   output logic       set_stg1,
   output logic       set_stg2,
   output logic       fire,
   output logic       rst_core,
   output logic       rst_chip,
   output logic       rst_sys
);
   import tmr_unit_pkg::*;

   logic [3:1] pulse_q;

   assign set_stg1 = period_hit && !stg1;
   assign set_stg2 = period_hit && stg1 && !stg2;
   assign fire     = period_hit && stg1 && stg2;

   for (genvar gk = 1; gk <= 3; gk++) begin : g_pulse
      always_ff @(posedge clk) begin
         if (!rst_n) pulse_q[gk] <= 1'b0;
         else        pulse_q[gk] <= fire && (rst_code == 2'(gk));
      end
   end

   assign rst_core = pulse_q[RK_CORE];
   assign rst_chip = pulse_q[RK_CHIP];
   assign rst_sys  = pulse_q[RK_SYS];

   // R8: at most one reset kind requested at a time
   a_r8_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_core, rst_chip, rst_sys}));

   // R8: each request lasts a single cycle
   a_r8_sys_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_sys |=> !rst_sys);
   a_r8_core_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_core |=> !rst_core);

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
   parameter int unsigned TB_W     = 12,
   parameter int unsigned RLD_W    = 16,
   parameter int unsigned FIT_TAP0 = 2,
   parameter int unsigned FIT_TAP1 = 3,
   parameter int unsigned FIT_TAP2 = 4,
   parameter int unsigned FIT_TAP3 = 5,
   parameter int unsigned WDT_TAP0 = 4,
   parameter int unsigned WDT_TAP1 = 5,
   parameter int unsigned WDT_TAP2 = 6,
   parameter int unsigned WDT_TAP3 = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TB_W-1:0]  tb_value,
   input  logic             tb_tick,
   input  logic             ctl_we,
   input  logic [31:0]      ctl_wdata,
   input  logic             sts_we,
   input  logic [31:0]      sts_wdata,
   input  logic             rld_we,
   input  logic [RLD_W-1:0] rld_wdata,
   output logic [31:0]      ctl_q,
   output logic [31:0]      sts_q,
   output logic             irq_pit,
   output logic             irq_fit,
   output logic             irq_wdt,
   output logic             rst_core,
   output logic             rst_chip,
   output logic             rst_sys
);
   import tmr_unit_pkg::*;

   localparam int unsigned STS_N = 32 - S_LOW;

   logic [31:0]      ctl_r;
   logic [31:S_LOW]  sts_r;
   logic [31:S_LOW]  sts_nx;
   logic             pit_expire;
   logic             fit_rise;
   logic             wdt_rise;
   logic             wd_set1;
   logic             wd_set2;
   logic             wd_fire;
   logic             unused_bits;

   assign unused_bits = ^{ctl_r[C_ARLD-1:0], sts_wdata[S_LOW-1:0]};

   // control word
   always_ff @(posedge clk) begin
      if (!rst_n)      ctl_r <= '0;
      else if (ctl_we) ctl_r <= ctl_wdata;
   end

   interval_counter #(.RLD_W(RLD_W)) i_pit (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctl_r[C_PIE]),
      .auto_rld (ctl_r[C_ARLD]),
      .tick     (tb_tick),
      .ld_we    (rld_we),
      .ld_val   (rld_wdata),
      .expire   (pit_expire)
   );

   tap_rise_sel #(
      .TB_W(TB_W), .TAP0(FIT_TAP0), .TAP1(FIT_TAP1), .TAP2(FIT_TAP2), .TAP3(FIT_TAP3)
   ) i_fit_tap (
      .clk      (clk),
      .rst_n    (rst_n),
      .tb_value (tb_value),
      .sel      (ctl_r[C_FPER_HI:C_FPER_LO]),
      .rise     (fit_rise)
   );

   tap_rise_sel #(
      .TB_W(TB_W), .TAP0(WDT_TAP0), .TAP1(WDT_TAP1), .TAP2(WDT_TAP2), .TAP3(WDT_TAP3)
   ) i_wdt_tap (
      .clk      (clk),
      .rst_n    (rst_n),
      .tb_value (tb_value),
      .sel      (ctl_r[C_WPER_HI:C_WPER_LO]),
      .rise     (wdt_rise)
   );

   watchdog_seq i_wdog (
      .clk        (clk),
      .rst_n      (rst_n),
      .period_hit (wdt_rise),
      .stg1       (sts_r[S_WSTG1]),
      .stg2       (sts_r[S_WSTG2]),
      .rst_code   (ctl_r[C_WRST_HI:C_WRST_LO]),
      .set_stg1   (wd_set1),
      .set_stg2   (wd_set2),
      .fire       (wd_fire),
      .rst_core   (rst_core),
      .rst_chip   (rst_chip),
      .rst_sys    (rst_sys)
   );

   // status word: clear first, then events win
   always_comb begin
      sts_nx = sts_r;
      if (sts_we) sts_nx = sts_nx & ~sts_wdata[31:S_LOW];
      if (pit_expire) sts_nx[S_PIT]   = 1'b1;
      if (fit_rise)   sts_nx[S_FIT]   = 1'b1;
      if (wd_set1)    sts_nx[S_WSTG1] = 1'b1;
      if (wd_set2)    sts_nx[S_WSTG2] = 1'b1;
      if (wd_fire)    sts_nx[S_WRS_HI:S_WRS_LO] = ctl_r[C_WRST_HI:C_WRST_LO];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sts_r <= '0;
      else        sts_r <= sts_nx;
   end

   assign ctl_q   = ctl_r;
   assign sts_q   = {sts_r, {S_LOW{1'b0}}};
   assign irq_pit = sts_r[S_PIT]   & ctl_r[C_PIE];
   assign irq_fit = sts_r[S_FIT]   & ctl_r[C_FIE];
   assign irq_wdt = sts_r[S_WSTG2] & ctl_r[C_WIE];

   if (STS_N != 6) begin : g_bad_layout
      $error("tmr_unit: unexpected status layout");
   end

   // R2: an interval expiry is visible in the status word next cycle
   a_r2_pit_sets: assert property (@(posedge clk) disable iff (!rst_n)
      pit_expire |=> sts_q[S_PIT]);

   // R5: a fixed-period rise is visible in the status word next cycle
   a_r5_fit_sets: assert property (@(posedge clk) disable iff (!rst_n)
      fit_rise |=> sts_q[S_FIT]);

   // R7: the second stage only follows the first
   a_r7_stage_order: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[S_WSTG2]) |-> $past(sts_q[S_WSTG1]));

   // R8: a reset request only follows a period seen with both stages set
   a_r8_req_after_stages: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_core || rst_chip || rst_sys) |-> $past(sts_q[S_WSTG1] && sts_q[S_WSTG2]));

endmodule

// File: tb/test_tmr_unit.sv
module test_tmr_unit;
   localparam int unsigned TB_W  = 12;
   localparam int unsigned RLD_W = 16;
   localparam int FT[4] = '{2, 3, 4, 5};
   localparam int WT[4] = '{4, 5, 6, 7};

   logic             clk = 1'b0;
   logic             rst_n;
   logic [TB_W-1:0]  tb_value;
   logic             tb_tick;
   logic             ctl_we;
   logic [31:0]      ctl_wdata;
   logic             sts_we;
   logic [31:0]      sts_wdata;
   logic             rld_we;
   logic [RLD_W-1:0] rld_wdata;
   logic [31:0]      ctl_q;
   logic [31:0]      sts_q;
   logic             irq_pit, irq_fit, irq_wdt;
   logic             rst_core, rst_chip, rst_sys;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #5 clk = ~clk;

   tmr_unit #(
      .TB_W(TB_W), .RLD_W(RLD_W),
      .FIT_TAP0(FT[0]), .FIT_TAP1(FT[1]), .FIT_TAP2(FT[2]), .FIT_TAP3(FT[3]),
      .WDT_TAP0(WT[0]), .WDT_TAP1(WT[1]), .WDT_TAP2(WT[2]), .WDT_TAP3(WT[3])
   ) i_tmr_unit (
      .clk(clk), .rst_n(rst_n), .tb_value(tb_value), .tb_tick(tb_tick),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .sts_we(sts_we), .sts_wdata(sts_wdata),
      .rld_we(rld_we), .rld_wdata(rld_wdata), .ctl_q(ctl_q), .sts_q(sts_q),
      .irq_pit(irq_pit), .irq_fit(irq_fit), .irq_wdt(irq_wdt),
      .rst_core(rst_core), .rst_chip(rst_chip), .rst_sys(rst_sys)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one clock; strobes drop after the edge
   task automatic cyc();
      @(posedge clk);
      #1;
      ctl_we  = 1'b0;
      sts_we  = 1'b0;
      rld_we  = 1'b0;
      tb_tick = 1'b0;
   endtask

   task automatic wr_ctl(input logic [31:0] v);
      ctl_we = 1'b1; ctl_wdata = v; cyc();
   endtask

   task automatic clr_all();
      sts_we = 1'b1; sts_wdata = 32'hFFFF_FFFF; cyc();
   endtask

   task automatic rise_bit(input int b);
      tb_value = '0; cyc();
      tb_value = '0; tb_value[b] = 1'b1; cyc();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: run did not complete, actual %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; tb_value = '0; tb_tick = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
      sts_we = 1'b0; sts_wdata = '0; rld_we = 1'b0; rld_wdata = '0;
      cyc(); cyc(); cyc();
      rst_n = 1'b1;
      cyc();

      // R1 reset state
      chk("R1", "ctl_q", ctl_q, 32'h0);
      chk("R1", "sts_q", sts_q, 32'h0);
      chk("R1", "irqs", {29'h0, irq_pit, irq_fit, irq_wdt}, 32'h0);
      chk("R1", "resets", {29'h0, rst_core, rst_chip, rst_sys}, 32'h0);

      // R10 control readback
      wr_ctl(32'hA5C3_0F96);
      chk("R10", "ctl_q", ctl_q, 32'hA5C3_0F96);
      wr_ctl(32'h0);
      chk("R10", "ctl_q zero", ctl_q, 32'h0);
      clr_all();

      // R5 sweep: each select code against every time-base bit
      for (int s = 0; s < 4; s++) begin
         wr_ctl((32'(s) << 24) | (32'h1 << 23));
         for (int b = 0; b < int'(TB_W); b++) begin
            tb_value = '0; sts_we = 1'b1; sts_wdata = 32'hFFFF_FFFF; cyc();
            tb_value = '0; tb_value[b] = 1'b1; cyc();
            chk("R5", $sformatf("fit sel%0d bit%0d", s, b), 32'(sts_q[26]), 32'(b == FT[s]));
            chk("R5", $sformatf("irq_fit sel%0d bit%0d", s, b), 32'(irq_fit), 32'(b == FT[s]));
         end
      end

      // R6 sweep: watchdog tap select, first stage
      for (int s = 0; s < 4; s++) begin
         wr_ctl(32'(s) << 30);
         for (int b = 0; b < int'(TB_W); b++) begin
            tb_value = '0; sts_we = 1'b1; sts_wdata = 32'hFFFF_FFFF; cyc();
            tb_value = '0; tb_value[b] = 1'b1; cyc();
            chk("R6", $sformatf("wdt sel%0d bit%0d", s, b), 32'(sts_q[31]), 32'(b == WT[s]));
         end
      end
      tb_value = '0; cyc();

      // R7 / R8 watchdog stages and every reset code
      for (int c = 0; c < 4; c++) begin
         wr_ctl((32'(c) << 28) | (32'h1 << 27));
         clr_all();
         rise_bit(WT[0]);
         chk("R7", $sformatf("stage1 code%0d", c), sts_q[31:28], 32'h8);
         chk("R7", "irq_wdt after stage1", 32'(irq_wdt), 32'h0);
         rise_bit(WT[0]);
         chk("R7", $sformatf("stage2 code%0d", c), sts_q[31:28], 32'hC);
         chk("R7", "irq_wdt after stage2", 32'(irq_wdt), 32'h1);
         tb_value = '0; cyc();
         chk("R8", "no request before third period", {rst_core, rst_chip, rst_sys}, 32'h0);
         tb_value[WT[0]] = 1'b1; cyc();
         chk("R8", $sformatf("recorded kind code%0d", c), sts_q[29:28], 32'(c));
         chk("R8", $sformatf("pulse code%0d", c), {rst_core, rst_chip, rst_sys},
             (c == 0) ? 32'h0 : (c == 1) ? 32'h4 : (c == 2) ? 32'h2 : 32'h1);
         cyc();
         chk("R8", $sformatf("pulse ends code%0d", c), {rst_core, rst_chip, rst_sys}, 32'h0);
      end
      tb_value = '0;
      wr_ctl(32'h0);
      clr_all();

      // R9 write-ones-to-clear
      tb_value = '0; cyc();
      tb_value = '0; tb_value[FT[0]] = 1'b1; tb_value[WT[0]] = 1'b1; cyc();
      chk("R9", "two bits set", sts_q, 32'h8400_0000);
      sts_we = 1'b1; sts_wdata = 32'h0400_0000; cyc();
      chk("R9", "clear bit 26 only", sts_q, 32'h8000_0000);
      sts_we = 1'b1; sts_wdata = 32'h0; cyc();
      chk("R9", "zero write keeps", sts_q, 32'h8000_0000);
      tb_value = '0; cyc();
      tb_value[FT[0]] = 1'b1; sts_we = 1'b1; sts_wdata = 32'hFFFF_FFFF; cyc();
      chk("R9", "event beats clear", sts_q, 32'h0400_0000);
      tb_value = '0;
      clr_all();

      // R2 / R3 interval timer with and without auto-reload
      for (int n = 2; n <= 6; n++) begin
         wr_ctl((32'h1 << 26) | (32'h1 << 22));
         clr_all();
         rld_we = 1'b1; rld_wdata = 16'(n); cyc();
         for (int k = 1; k <= n; k++) begin
            tb_tick = 1'b1; cyc();
            chk("R2", $sformatf("N%0d tick%0d", n, k), 32'(sts_q[27]), 32'(k == n));
         end
         chk("R2", $sformatf("irq_pit N%0d", n), 32'(irq_pit), 32'h1);
         clr_all();
         for (int k = 1; k <= n; k++) begin
            tb_tick = 1'b1; cyc();
            chk("R3", $sformatf("reloaded N%0d tick%0d", n, k), 32'(sts_q[27]), 32'(k == n));
         end
         wr_ctl(32'h1 << 26);
         clr_all();
         rld_we = 1'b1; rld_wdata = 16'(n); cyc();
         for (int k = 1; k <= n; k++) begin
            tb_tick = 1'b1; cyc();
         end
         chk("R3", $sformatf("one-shot expiry N%0d", n), 32'(sts_q[27]), 32'h1);
         clr_all();
         for (int k = 1; k <= 2 * n; k++) begin
            tb_tick = 1'b1; cyc();
         end
         chk("R3", $sformatf("one-shot stays idle N%0d", n), 32'(sts_q[27]), 32'h0);
      end

      // R2 interrupt masked by control bit 26 while status stays
      rld_we = 1'b1; rld_wdata = 16'd2; cyc();
      tb_tick = 1'b1; cyc();
      tb_tick = 1'b1; cyc();
      wr_ctl(32'h0);
      chk("R2", "status kept when disabled", 32'(sts_q[27]), 32'h1);
      chk("R2", "irq_pit masked", 32'(irq_pit), 32'h0);
      clr_all();

      // R4 small reload values and disabled timer
      wr_ctl((32'h1 << 26) | (32'h1 << 22));
      for (int v = 0; v < 2; v++) begin
         rld_we = 1'b1; rld_wdata = 16'(v); cyc();
         for (int k = 0; k < 10; k++) begin
            tb_tick = 1'b1; cyc();
         end
         chk("R4", $sformatf("reload %0d never expires", v), 32'(sts_q[27]), 32'h0);
      end
      wr_ctl(32'h1 << 22);
      rld_we = 1'b1; rld_wdata = 16'd3; cyc();
      for (int k = 0; k < 10; k++) begin
         tb_tick = 1'b1; cyc();
      end
      chk("R4", "disabled never expires", 32'(sts_q[27]), 32'h0);
      wr_ctl((32'h1 << 26) | (32'h1 << 22));
      rld_we = 1'b1; rld_wdata = 16'd5; cyc();
      tb_tick = 1'b1; cyc();
      tb_tick = 1'b1; cyc();
      wr_ctl(32'h1 << 22);
      wr_ctl((32'h1 << 26) | (32'h1 << 22));
      for (int k = 0; k < 12; k++) begin
         tb_tick = 1'b1; cyc();
      end
      chk("R4", "stopped countdown stays stopped", 32'(sts_q[27]), 32'h0);
      rld_we = 1'b1; rld_wdata = 16'd3; cyc();
      for (int k = 0; k < 3; k++) begin
         tb_tick = 1'b1; cyc();
      end
      chk("R4", "reload write restarts", 32'(sts_q[27]), 32'h1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule